// File: doc/BRIEF.md
# Transmit Flow-Control Gate

This block sits beside a serial transmitter and decides whether the transmitter may begin a new character. It watches one of two active-low modem handshake inputs, clear-to-send or data-set-ready, chosen by a select bit. A high level on the watched line means the far end cannot accept more data. Two synchronizer flops bring each raw pin into the clock domain before the block uses it.

When automatic gating is on, a high level on the watched line withdraws the transmit permit. A character already being shifted out still runs through its stop bit. The permit is frozen while the transmitter reports busy, so the new level takes effect only at the next character boundary. Transmission resumes once the watched line is low again. When automatic gating is off, the permit is always granted.

The block also raises a sticky modem-change interrupt flag on every edge of the watched line. The flag is set only when the line-change interrupt enable and the extended-feature enable are both set. It stays set until a clear strobe arrives.

Top module: `tx_flow_gate`

## Requirements
- R1: After reset, with automatic gating on, `tx_permit` is 0, `tx_load` is 0 and `mdm_irq` is 0. Both synchronizers reset to the inactive (high) level.
- R2: `watch_dsr`=0 selects `cts_n` and `watch_dsr`=1 selects `dsr_n`. The unselected pin has no effect on `tx_permit` or `mdm_irq`.
- R3: While `auto_gate`=0, `tx_permit` is 1 in the same cycle, whatever the pin levels are.
- R4: With `auto_gate`=1 and `tx_busy`=0, a level change on the watched pin shows on `tx_permit` at the third rising edge after the change. A high level gives 0 and a low level gives 1.
- R5: While `tx_busy`=1, the registered permit holds its value. A pending change takes effect at the first rising edge with `tx_busy`=0, so a character in progress completes before any suspension.
- R6: `tx_load` equals `tx_start` AND NOT `tx_busy` AND `tx_permit`, in the same cycle.
- R7: With `line_irq_en`=1 and `ext_en`=1, both rising and falling edges of the watched pin set `mdm_irq` at the third rising edge after the change.
- R8: If `line_irq_en`=0 or `ext_en`=0, an edge does not set `mdm_irq`.
- R9: `mdm_irq` stays at 1 until `irq_clr` is sampled high, and then clears at that edge. If a new edge arrives in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Raw clear-to-send pin, active low |
| dsr_n | input | 1 | Raw data-set-ready pin, active low |
| watch_dsr | input | 1 | 0 watches cts_n, 1 watches dsr_n |
| auto_gate | input | 1 | Enables automatic transmit gating |
| ext_en | input | 1 | Extended-feature enable, qualifies the interrupt |
| line_irq_en | input | 1 | Modem-line change interrupt enable |
| tx_start | input | 1 | Transmitter requests to start a character |
| tx_busy | input | 1 | Transmitter is shifting a character (through stop bit) |
| irq_clr | input | 1 | Clear-on-read strobe for the interrupt flag |
| tx_permit | output | 1 | A new character may start |
| tx_load | output | 1 | Granted character start |
| mdm_irq | output | 1 | Sticky modem-line change flag |

## Verification
A pin change needs three rising edges to reach `tx_permit` and `mdm_irq`: two synchronizer stages and then the result register. A change of `tx_busy` or `watch_dsr` reaches the permit after one edge. `auto_gate` and the `tx_load` logic act in the same cycle. The bench keeps a cycle-stepped model with these delays and updates it on the rising edge. It drives inputs and compares every output on the falling edge, so each result is read in the cycle it is due. The directed cases also check the intermediate cycles, to confirm that a result does not appear early.

// File: rtl/tx_flow_gate_pkg.sv
package tx_flow_gate_pkg;

    localparam int unsigned NUM_PINS = 2;
    localparam int unsigned PIN_CTS  = 0;
    localparam int unsigned PIN_DSR  = 1;

    typedef struct packed {
        logic permit;
    } gate_state_t;

    typedef struct packed {
        logic pend;
    } irq_state_t;

endpackage

// File: rtl/tx_flow_sync.sv
module tx_flow_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_sync,
    output logic pin_prev
);

    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], pin_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign pin_sync = chain_q[STAGES-1];
    assign pin_prev = chain_q[STAGES];

    initial begin
        AST_SYNC_DEPTH: assert (STAGES >= 2); // R4
    end

endmodule

// File: rtl/tx_flow_irq.sv
module tx_flow_irq
    import tx_flow_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_ev,
    input  logic irq_en,
    input  logic irq_clr,
    output logic pend
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (irq_clr) begin
            st_d.pend = 1'b0;
        end
        if (edge_ev && irq_en) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(irq_en)); // R8
    AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(edge_ev)); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend && !irq_clr |=> st_q.pend); // R9
    AST_IRQ_FALL_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.pend) |-> $past(irq_clr)); // R9

endmodule

// File: rtl/tx_flow_gate.sv
module tx_flow_gate
    import tx_flow_gate_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic dsr_n,
    input  logic watch_dsr,
    input  logic auto_gate,
    input  logic ext_en,
    input  logic line_irq_en,
    input  logic tx_start,
    input  logic tx_busy,
    input  logic irq_clr,
    output logic tx_permit,
    output logic tx_load,
    output logic mdm_irq
);

    logic [NUM_PINS-1:0] pin_raw;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_prev;

    assign pin_raw[PIN_CTS] = cts_n;
    assign pin_raw[PIN_DSR] = dsr_n;

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        tx_flow_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_raw  (pin_raw[gi]),
            .pin_sync (pin_sync[gi]),
            .pin_prev (pin_prev[gi])
        );
    end

    logic watched_lvl;
    logic watched_edge;

    always_comb begin
        if (watch_dsr) begin
            watched_lvl  = pin_sync[PIN_DSR];
            watched_edge = pin_sync[PIN_DSR] ^ pin_prev[PIN_DSR];
        end else begin
            watched_lvl  = pin_sync[PIN_CTS];
            watched_edge = pin_sync[PIN_CTS] ^ pin_prev[PIN_CTS];
        end
    end

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!tx_busy) begin
            st_d.permit = ~watched_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_permit = ~auto_gate | st_q.permit;
    assign tx_load   = tx_start & ~tx_busy & tx_permit;

    tx_flow_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_ev (watched_edge),
        .irq_en  (line_irq_en & ext_en),
        .irq_clr (irq_clr),
        .pend    (mdm_irq)
    );

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> $stable(st_q.permit)); // R5
    AST_RESUME_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.permit) |-> $past(!watched_lvl)); // R4
    AST_SUSPEND_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.permit) |-> $past(watched_lvl && !tx_busy)); // R4

endmodule

// File: tb/tx_flow_gate_bench.sv
module tx_flow_gate_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_n = 1'b1, dsr_n = 1'b1, watch_dsr = 1'b0, auto_gate = 1'b1;
    logic ext_en = 1'b0, line_irq_en = 1'b0, tx_start = 1'b0, tx_busy = 1'b0;
    logic irq_clr = 1'b0;
    logic tx_permit, tx_load, mdm_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tx_flow_gate u_tx_flow_gate (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n),
        .watch_dsr(watch_dsr), .auto_gate(auto_gate), .ext_en(ext_en),
        .line_irq_en(line_irq_en), .tx_start(tx_start), .tx_busy(tx_busy),
        .irq_clr(irq_clr), .tx_permit(tx_permit), .tx_load(tx_load),
        .mdm_irq(mdm_irq)
    );

    // Requirement model: two sync stages plus history, then result registers.
    logic [2:0] m_cts, m_dsr;
    logic m_perm, m_irq;

    function automatic logic f_lvl(input logic [2:0] c, input logic [2:0] d, input logic sel);
        return sel ? d[1] : c[1];
    endfunction

    function automatic logic f_edge(input logic [2:0] c, input logic [2:0] d, input logic sel);
        return sel ? (d[1] ^ d[2]) : (c[1] ^ c[2]);
    endfunction

    function automatic logic f_permit(input logic auto, input logic perm);
        return !auto || perm;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cts <= 3'b111; m_dsr <= 3'b111; m_perm <= 1'b0; m_irq <= 1'b0;
        end else begin
            m_cts <= {m_cts[1:0], cts_n};
            m_dsr <= {m_dsr[1:0], dsr_n};
            if (!tx_busy) m_perm <= !f_lvl(m_cts, m_dsr, watch_dsr);
            m_irq <= (f_edge(m_cts, m_dsr, watch_dsr) && line_irq_en && ext_en)
                     || (m_irq && !irq_clr);
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all(input string tp, input string tl, input string ti);
        logic ep;
        ep = f_permit(auto_gate, m_perm);
        chk(tp, tx_permit, ep);
        chk(tl, tx_load, tx_start && !tx_busy && ep);
        chk(ti, mdm_irq, m_irq);
    endtask

    task automatic step(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            cmp_all(tag, "R6", tag);
        end
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        chk("R1", tx_permit, 1'b0);
        chk("R1", mdm_irq, 1'b0);
        rst_n = 1'b1;
        step(2, "R1");
        chk("R1", tx_permit, 1'b0);

        // R4 resume latency: low visible at third edge, not before
        cts_n = 1'b0; tx_start = 1'b1;
        step(2, "R4");
        chk("R4", tx_permit, 1'b0);
        step(1, "R4");
        chk("R4", tx_permit, 1'b1);
        chk("R6", tx_load, 1'b1);

        // R2 unselected pin ignored
        dsr_n = 1'b1;
        step(4, "R2");
        chk("R2", tx_permit, 1'b1);
        watch_dsr = 1'b1;
        step(1, "R2");
        chk("R2", tx_permit, 1'b0);
        cts_n = 1'b1;
        step(4, "R2");
        chk("R2", tx_permit, 1'b0);

        // R3 gating disabled
        auto_gate = 1'b0;
        #1;
        chk("R3", tx_permit, 1'b1);
        auto_gate = 1'b1;
        dsr_n = 1'b0;
        step(4, "R4");
        chk("R4", tx_permit, 1'b1);

        // R5 busy holds permit until boundary
        tx_busy = 1'b1;
        dsr_n = 1'b1;
        step(6, "R5");
        chk("R5", tx_permit, 1'b1);
        chk("R6", tx_load, 1'b0);
        tx_busy = 1'b0;
        step(1, "R5");
        chk("R5", tx_permit, 1'b0);

        // R8 enables gate the interrupt
        ext_en = 1'b0; line_irq_en = 1'b1;
        dsr_n = 1'b0;
        step(4, "R8");
        chk("R8", mdm_irq, 1'b0);
        ext_en = 1'b1; line_irq_en = 1'b0;
        dsr_n = 1'b1;
        step(4, "R8");
        chk("R8", mdm_irq, 1'b0);

        // R7 both edges; R9 sticky and clear
        line_irq_en = 1'b1;
        dsr_n = 1'b0;
        step(2, "R7");
        chk("R7", mdm_irq, 1'b0);
        step(1, "R7");
        chk("R7", mdm_irq, 1'b1);
        step(5, "R9");
        chk("R9", mdm_irq, 1'b1);
        irq_clr = 1'b1;
        step(1, "R9");
        chk("R9", mdm_irq, 1'b0);
        irq_clr = 1'b0;
        dsr_n = 1'b1;
        step(3, "R7");
        chk("R7", mdm_irq, 1'b1);
        // set wins over clear
        dsr_n = 1'b0;
        step(2, "R9");
        irq_clr = 1'b1;
        step(1, "R9");
        chk("R9", mdm_irq, 1'b1);
        irq_clr = 1'b0;

        // constrained random phase
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 7) == 0) cts_n = ~cts_n;
            if ($urandom_range(0, 7) == 0) dsr_n = ~dsr_n;
            if ($urandom_range(0, 31) == 0) watch_dsr = ~watch_dsr;
            if ($urandom_range(0, 63) == 0) auto_gate = ~auto_gate;
            if ($urandom_range(0, 15) == 0) tx_busy = ~tx_busy;
            ext_en      = ($urandom_range(0, 7) != 0);
            line_irq_en = ($urandom_range(0, 7) != 0);
            tx_start    = $urandom_range(0, 1);
            irq_clr     = ($urandom_range(0, 9) == 0);
            @(posedge clk);
            @(negedge clk);
            cmp_all("R4", "R6", "R7");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule